// File: doc/BRIEF.md
# Sixty-Four-Bit Integer Register File with Width-Aware Merging

This block stores the integer working registers of a processor core: sixteen 64-bit entries, one write port and two independent read ports. Every access carries an operand width (8, 16, 32 or 64 bits) and an extension-prefix flag. A write is merged into its destination register by a fixed rule. A 32-bit result clears the upper half of the register. An 8-bit or 16-bit result leaves every bit it does not cover as it was. A 64-bit result replaces the whole register. A read returns only the bits of the requested width, with zeros above them on the 64-bit output.

The prefix flag selects between two ways of addressing operands. With the prefix, the full 4-bit index reaches all sixteen registers, all four widths are legal, and an 8-bit selector names the lowest byte of the register with that number. Without the prefix, only bits 2:0 of the index are used. A 64-bit request falls back to 32 bits. Byte selectors 4 to 7 name the second byte (bits 15:8) of registers 0 to 3, as on older machines. The instruction pointer, flags, vector registers and instruction decode sit outside this block.

The block holds no state machine. Its only state is the register array, with a synchronous reset and one write committed per clock edge.

Top module: `gpr_file`

## Requirements
- R1: While `rst` is high at a rising clock edge, every register is set to zero.
- R2: A write with the prefix and width code 3 (64 bits) replaces all 64 bits of the register named by the 4-bit index.
- R3: A write of width code 2 (32 bits) stores the low 32 data bits and clears bits 63:32 of the destination.
- R4: A write of width code 1 (16 bits) stores data bits 15:0 into register bits 15:0 and keeps bits 63:16.
- R5: A write of width code 0 (8 bits) to a low-byte lane stores data bits 7:0 into bits 7:0 and keeps bits 63:8.
- R6: With the prefix, an 8-bit selector of 0 to 15 reads or writes bits 7:0 of that same register, including selectors 4 to 7.
- R7: Without the prefix, 8-bit selectors 4 to 7 read or write bits 15:8 of registers 0 to 3. An 8-bit write there keeps all other bits.
- R8: Without the prefix, index bit 3 is ignored, so index 9 reaches register 1.
- R9: Without the prefix, width code 3 acts as width code 2. Reads return only the low 32 bits, and writes zero-extend.
- R10: Each read port returns the selected width right-aligned and zero-padded to 64 bits. Width codes are 0=8, 1=16, 2=32 and 3=64 bits.
- R11: Reads are combinational from the stored array. A read of the register being written returns the old value until the rising edge that commits the write.
- R12: The two read ports decode and return their operands independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Commit a write at the next rising edge |
| wr_idx | input | 4 | Write register or byte selector |
| wr_width | input | 2 | Write width code |
| wr_ext | input | 1 | Write extension prefix present |
| wr_data | input | 64 | Write data, right-aligned |
| rd0_idx | input | 4 | Read port 0 register or byte selector |
| rd0_width | input | 2 | Read port 0 width code |
| rd0_ext | input | 1 | Read port 0 extension prefix present |
| rd0_data | output | 64 | Read port 0 result, zero-padded |
| rd1_idx | input | 4 | Read port 1 register or byte selector |
| rd1_width | input | 2 | Read port 1 width code |
| rd1_ext | input | 1 | Read port 1 extension prefix present |
| rd1_data | output | 64 | Read port 1 result, zero-padded |

## Verification
Read results depend only on the stored array and the read controls, so they are due in the same cycle as their inputs. A merged write is due one rising edge after `wr_en` is sampled high. The bench changes every input on the falling edge and samples the read ports 2 ns later, inside the same low phase. A write issued at one falling edge is checked only after the following falling edge. The same-cycle test samples once before the committing edge, where the old value is expected, and once after it, where the new value is expected.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    localparam int unsigned XLEN     = 64;
    localparam int unsigned NREGS    = 16;
    localparam int unsigned IDX_W    = $clog2(NREGS);
    localparam int unsigned NRD      = 2;

    typedef enum logic [1:0] {
        OPW_B = 2'd0,
        OPW_H = 2'd1,
        OPW_W = 2'd2,
        OPW_D = 2'd3
    } opw_e;

    typedef struct packed {
        logic [IDX_W-1:0] slot;
        logic             hi_lane;
        opw_e             width;
    } acc_t;

endpackage

// File: rtl/gpr_decode.sv
module gpr_decode
    import gpr_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  opw_e             width,
    input  logic             ext,
    output acc_t             acc
);

    always_comb begin
        acc.hi_lane = 1'b0;
        acc.width   = width;
        if (ext) begin
            acc.slot = idx;
        end else begin
            acc.slot = {1'b0, idx[IDX_W-2:0]};
            if (width == OPW_D) begin
                acc.width = OPW_W;
            end
            if (width == OPW_B && idx[2]) begin
                acc.slot    = {{(IDX_W-2){1'b0}}, idx[1:0]};
                acc.hi_lane = 1'b1;
            end
        end
    end

endmodule

// File: rtl/gpr_merge.sv
module gpr_merge
    import gpr_pkg::*;
(
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] data,
    input  acc_t            acc,
    output logic [XLEN-1:0] merged
);

    always_comb begin
        unique case (acc.width)
            OPW_B: begin
                if (acc.hi_lane) begin
                    merged = {old_val[XLEN-1:16], data[7:0], old_val[7:0]};
                end else begin
                    merged = {old_val[XLEN-1:8], data[7:0]};
                end
            end
            OPW_H: merged = {old_val[XLEN-1:16], data[15:0]};
            OPW_W: merged = {{(XLEN-32){1'b0}}, data[31:0]};
            OPW_D: merged = data;
            default: merged = old_val;
        endcase
    end

endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
    import gpr_pkg::*;
(
    input  logic [XLEN-1:0]  regs [NREGS],
    input  logic [IDX_W-1:0] idx,
    input  opw_e             width,
    input  logic             ext,
    output logic [XLEN-1:0]  data
);

    acc_t            acc;
    logic [XLEN-1:0] word;

    gpr_decode u_dec (
        .idx   (idx),
        .width (width),
        .ext   (ext),
        .acc   (acc)
    );

    assign word = regs[acc.slot];

    always_comb begin
        unique case (acc.width)
            OPW_B: begin
                if (acc.hi_lane) begin
                    data = {{(XLEN-8){1'b0}}, word[15:8]};
                end else begin
                    data = {{(XLEN-8){1'b0}}, word[7:0]};
                end
            end
            OPW_H: data = {{(XLEN-16){1'b0}}, word[15:0]};
            OPW_W: data = {{(XLEN-32){1'b0}}, word[31:0]};
            OPW_D: data = word;
            default: data = '0;
        endcase
    end

endmodule

// File: rtl/gpr_file.sv
module gpr_file
    import gpr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_width,
    input  logic             wr_ext,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [IDX_W-1:0] rd0_idx,
    input  logic [1:0]       rd0_width,
    input  logic             rd0_ext,
    output logic [XLEN-1:0]  rd0_data,
    input  logic [IDX_W-1:0] rd1_idx,
    input  logic [1:0]       rd1_width,
    input  logic             rd1_ext,
    output logic [XLEN-1:0]  rd1_data
);

    logic [XLEN-1:0]  regs [NREGS];
    acc_t             wacc;
    logic [XLEN-1:0]  wmerged;

    logic [IDX_W-1:0] rp_idx   [NRD];
    opw_e             rp_width [NRD];
    logic             rp_ext   [NRD];
    logic [XLEN-1:0]  rp_data  [NRD];

    gpr_decode u_wdec (
        .idx   (wr_idx),
        .width (opw_e'(wr_width)),
        .ext   (wr_ext),
        .acc   (wacc)
    );

    gpr_merge u_merge (
        .old_val (regs[wacc.slot]),
        .data    (wr_data),
        .acc     (wacc),
        .merged  (wmerged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) begin
                regs[i] <= '0;
            end
        end else if (wr_en) begin
            regs[wacc.slot] <= wmerged;
        end
    end

    assign rp_idx[0]   = rd0_idx;
    assign rp_width[0] = opw_e'(rd0_width);
    assign rp_ext[0]   = rd0_ext;
    assign rp_idx[1]   = rd1_idx;
    assign rp_width[1] = opw_e'(rd1_width);
    assign rp_ext[1]   = rd1_ext;

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        gpr_read_port u_rp (
            .regs  (regs),
            .idx   (rp_idx[p]),
            .width (rp_width[p]),
            .ext   (rp_ext[p]),
            .data  (rp_data[p])
        );
    end

    assign rd0_data = rp_data[0];
    assign rd1_data = rp_data[1];

endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk
    import gpr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [1:0]       wr_width,
    input logic             wr_ext,
    input logic [XLEN-1:0]  wr_data,
    input logic [IDX_W-1:0] rd0_idx,
    input logic [1:0]       rd0_width,
    input logic             rd0_ext,
    input logic [XLEN-1:0]  rd0_data,
    input logic [IDX_W-1:0] rd1_idx,
    input logic [1:0]       rd1_width,
    input logic             rd1_ext,
    input logic [XLEN-1:0]  rd1_data
);

    logic rd0_full;
    assign rd0_full = rd0_ext && rd0_width == 2'd3;

    AST_W64_REPLACE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en && wr_ext && wr_width == 2'd3) && rd0_full && rd0_idx == $past(wr_idx))
        |-> rd0_data == $past(wr_data)); // R2

    AST_W32_ZEXT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en && wr_ext && wr_width == 2'd2) && rd0_full && rd0_idx == $past(wr_idx))
        |-> rd0_data == {32'd0, $past(wr_data[31:0])}); // R3

    AST_W16_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en && wr_ext && wr_width == 2'd1 && rd0_full && rd0_idx == wr_idx)
         && rd0_full && rd0_idx == $past(wr_idx))
        |-> rd0_data == {$past(rd0_data[63:16]), $past(wr_data[15:0])}); // R4

    AST_W8_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en && wr_ext && wr_width == 2'd0 && rd0_full && rd0_idx == wr_idx)
         && rd0_full && rd0_idx == $past(wr_idx))
        |-> rd0_data == {$past(rd0_data[63:8]), $past(wr_data[7:0])}); // R5

    AST_PAD_BYTE: assert property (@(posedge clk) disable iff (rst)
        (rd0_width == 2'd0) |-> rd0_data[63:8] == 56'd0); // R10

    AST_PAD_HALF: assert property (@(posedge clk) disable iff (rst)
        (rd1_width == 2'd1) |-> rd1_data[63:16] == 48'd0); // R10

    AST_NOEXT_NARROW: assert property (@(posedge clk) disable iff (rst)
        (!rd1_ext) |-> rd1_data[63:32] == 32'd0); // R9

endmodule

bind gpr_file gpr_file_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_width  (wr_width),
    .wr_ext    (wr_ext),
    .wr_data   (wr_data),
    .rd0_idx   (rd0_idx),
    .rd0_width (rd0_width),
    .rd0_ext   (rd0_ext),
    .rd0_data  (rd0_data),
    .rd1_idx   (rd1_idx),
    .rd1_width (rd1_width),
    .rd1_ext   (rd1_ext),
    .rd1_data  (rd1_data)
);

// File: tb/gpr_file_tb.sv
module gpr_file_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [1:0]  wr_width = '0;
    logic        wr_ext = 1'b0;
    logic [63:0] wr_data = '0;
    logic [3:0]  rd0_idx = '0;
    logic [1:0]  rd0_width = '0;
    logic        rd0_ext = 1'b0;
    logic [63:0] rd0_data;
    logic [3:0]  rd1_idx = '0;
    logic [1:0]  rd1_width = '0;
    logic        rd1_ext = 1'b0;
    logic [63:0] rd1_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    gpr_file u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_width(wr_width),
        .wr_ext(wr_ext), .wr_data(wr_data), .rd0_idx(rd0_idx), .rd0_width(rd0_width),
        .rd0_ext(rd0_ext), .rd0_data(rd0_data), .rd1_idx(rd1_idx), .rd1_width(rd1_width),
        .rd1_ext(rd1_ext), .rd1_data(rd1_data)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] idx, input logic [1:0] w, input logic ext,
                            input logic [63:0] d);
        @(negedge clk);
        wr_idx = idx; wr_width = w; wr_ext = ext; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd0(input logic [3:0] idx, input logic [1:0] w, input logic ext,
                       input string req, input logic [63:0] exp);
        rd0_idx = idx; rd0_width = w; rd0_ext = ext;
        #2;
        check(req, rd0_data, exp);
    endtask

    task automatic test_reset;
        do_write(4'd5, 2'd3, 1'b1, 64'hDEAD_BEEF_0000_1111);
        rd0(4'd5, 2'd3, 1'b1, "R2", 64'hDEAD_BEEF_0000_1111);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd1_idx = 4'd15; rd1_width = 2'd3; rd1_ext = 1'b1;
        rd0(4'd5, 2'd3, 1'b1, "R1", 64'd0);
        check("R1", rd1_data, 64'd0);
    endtask

    task automatic test_widths;
        do_write(4'd10, 2'd3, 1'b1, 64'h0123_4567_89AB_CDEF);
        rd0(4'd10, 2'd3, 1'b1, "R2", 64'h0123_4567_89AB_CDEF);
        do_write(4'd10, 2'd2, 1'b1, 64'hFFFF_FFFF_1122_3344);
        rd0(4'd10, 2'd3, 1'b1, "R3", 64'h0000_0000_1122_3344);
        do_write(4'd3, 2'd3, 1'b1, 64'hA5A5_A5A5_A5A5_A5A5);
        do_write(4'd3, 2'd1, 1'b1, 64'hFFFF_FFFF_FFFF_5566);
        rd0(4'd3, 2'd3, 1'b1, "R4", 64'hA5A5_A5A5_A5A5_5566);
        do_write(4'd12, 2'd3, 1'b1, 64'h1111_2222_3333_4444);
        do_write(4'd12, 2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFBB);
        rd0(4'd12, 2'd3, 1'b1, "R5", 64'h1111_2222_3333_44BB);
    endtask

    task automatic test_bytes;
        do_write(4'd1, 2'd3, 1'b1, 64'hCAFE_0000_1234_5678);
        do_write(4'd5, 2'd0, 1'b1, 64'h0000_0000_0000_009C);
        rd0(4'd5, 2'd3, 1'b1, "R6", 64'h0000_0000_0000_009C);
        rd0(4'd1, 2'd3, 1'b1, "R6", 64'hCAFE_0000_1234_5678);
        do_write(4'd5, 2'd0, 1'b0, 64'h0000_0000_0000_0077);
        rd0(4'd1, 2'd3, 1'b1, "R7", 64'hCAFE_0000_1234_7778);
        rd0(4'd5, 2'd0, 1'b0, "R7", 64'h0000_0000_0000_0077);
        rd0(4'd5, 2'd0, 1'b1, "R6", 64'h0000_0000_0000_009C);
    endtask

    task automatic test_noext;
        rd0(4'd9, 2'd2, 1'b0, "R8", 64'h0000_0000_1234_7778);
        rd0(4'd1, 2'd3, 1'b0, "R9", 64'h0000_0000_1234_7778);
        do_write(4'd10, 2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        rd0(4'd2, 2'd3, 1'b1, "R9", 64'h0000_0000_FFFF_FFFF);
        rd0(4'd10, 2'd3, 1'b1, "R8", 64'h0000_0000_1122_3344);
    endtask

    task automatic test_pad_ports;
        do_write(4'd4, 2'd3, 1'b1, 64'h8877_6655_4433_2211);
        rd0(4'd4, 2'd0, 1'b1, "R10", 64'h11);
        rd0(4'd4, 2'd1, 1'b1, "R10", 64'h2211);
        rd0(4'd4, 2'd2, 1'b1, "R10", 64'h4433_2211);
        rd1_idx = 4'd3; rd1_width = 2'd3; rd1_ext = 1'b1;
        rd0(4'd4, 2'd3, 1'b1, "R12", 64'h8877_6655_4433_2211);
        check("R12", rd1_data, 64'hA5A5_A5A5_A5A5_5566);
    endtask

    task automatic test_same_cycle;
        @(negedge clk);
        wr_idx = 4'd4; wr_width = 2'd3; wr_ext = 1'b1; wr_data = 64'h0F0F_0F0F_0F0F_0F0F; wr_en = 1'b1;
        rd0(4'd4, 2'd3, 1'b1, "R11", 64'h8877_6655_4433_2211);
        @(negedge clk);
        wr_en = 1'b0;
        rd0(4'd4, 2'd3, 1'b1, "R11", 64'h0F0F_0F0F_0F0F_0F0F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd0(4'd0, 2'd3, 1'b1, "R1", 64'd0);
        test_reset;
        test_widths;
        test_bytes;
        test_noext;
        test_pad_ports;
        test_same_cycle;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #4000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule